// File: doc/BRIEF.md
# Reload Timer with Fine Period Adjust

This block is an 8-bit down-counter that reloads itself from a programmed value. A prescaled count-enable input paces it. Software supplies a reload value and starts or stops the timer with set and clear strobes for a run bit. A preset strobe copies the reload value into the counter at once. A mode input chooses between free-running (repeat) operation and a one-shot, in which the run bit clears itself at the first underflow.

Each underflow produces a one-cycle pulse. The pulse sets a sticky interrupt flag, which a clear strobe removes. It also toggles a square-wave timer clock that can pace a serial transfer or trigger a converter. With reload value n, one underflow period is n+1 enabled counts.

A 4-bit fine-adjust value k adds one extra count to the first k periods of every frame of 16 underflows. This makes fractional division ratios possible. The extra count delays the underflow pulse, the interrupt and the clock edge by the same amount.

Top module: `fine_reload_timer`

## Requirements
- R1: After reset `count`, `running`, `uf_pulse`, `irq` and `tmr_clk` are all 0.
- R2: While `running` is 1 and `preset` is 0, each cycle with `cnt_en` high lowers a nonzero `count` by one. While `running` is 0, `cnt_en` leaves `count` unchanged.
- R3: An enabled count at `count` = 0 that is not stretched reloads `count` with `reload_val`. It also drives `uf_pulse` high for that one following cycle. An unstretched period is therefore `reload_val`+1 enabled counts.
- R4: `preset` loads `reload_val` into `count` on the next edge and takes priority over counting, so no underflow occurs in that cycle. It also returns the frame index to 0 and cancels a pending stretch.
- R5: `run_set` sets the run bit and `run_clr` clears it. When both are high in the same cycle, `run_clr` wins.
- R6: With `mode_oneshot` = 1, the run bit is cleared on the same edge as the underflow. After that `count` stays at the reload value.
- R7: An underflow sets `irq`, and `irq_clr` clears it. When both happen in the same cycle, the set wins.
- R8: `tmr_clk` toggles on every underflow and on nothing else.
- R9: A frame index counts underflows modulo 16, starting at 0. A period whose index is below `fine_sel` lasts one extra enabled count, so for `fine_sel` = 0 every period is `reload_val`+1 counts.
- R10: Over any 16 consecutive periods with constant `reload_val` = n and `fine_sel` = k, the underflows span exactly 16·(n+1)+k enabled counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Prescaled count enable |
| reload_val | input | 8 | Reload value n |
| preset | input | 1 | Load reload value into counter now |
| run_set | input | 1 | Set run bit |
| run_clr | input | 1 | Clear run bit |
| mode_oneshot | input | 1 | 1 = one-shot, 0 = repeat |
| fine_sel | input | 4 | Stretched periods per 16-underflow frame |
| irq_clr | input | 1 | Clear interrupt flag |
| count | output | 8 | Current counter value |
| running | output | 1 | Run bit |
| uf_pulse | output | 1 | One-cycle underflow pulse |
| irq | output | 1 | Sticky interrupt request |
| tmr_clk | output | 1 | Timer output clock, toggles per underflow |

## Verification
An underflow can land in the same cycle as an interrupt clear. A preset can land in the same cycle as an enabled count at zero. Directed tests first run the counter down to zero with the fine adjust off, so the next enabled count is known to underflow, and then assert `irq_clr` or `preset` in exactly that cycle. The bench expects `irq` to stay set in the first case. In the second it expects the new reload value with no pulse and no clock toggle. Random stimulus also produces both collisions, and a cycle-accurate model written from the requirements judges them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        MODE_REPEAT  = 1'b0,
        MODE_ONESHOT = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_fine_ctl.sv
module tmr_fine_ctl #(
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              zero_tick,
    input  logic [FINE_W-1:0] fine_k,
    output logic              stretch
);
    typedef struct packed {
        logic [FINE_W-1:0] seq;
        logic              hold;
    } fine_t;

    fine_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        stretch = zero_tick && !st_q.hold && (st_q.seq < fine_k);
        if (preset) begin
            st_d.seq  = '0;
            st_d.hold = 1'b0;
        end else if (zero_tick) begin
            if (stretch) begin
                st_d.hold = 1'b1;
            end else begin
                st_d.hold = 1'b0;
                st_d.seq  = st_q.seq + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STRETCH_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hold) |-> ($past(st_q.seq) < $past(fine_k))); // R9
    AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && zero_tick) |-> !stretch); // R9
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_evt,
    input  logic irq_clr,
    output logic irq,
    output logic tmr_clk
);
    typedef struct packed {
        logic irq;
        logic tclk;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (uf_evt)       st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
        if (uf_evt)       st_d.tclk = !st_q.tclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq     = st_q.irq;
    assign tmr_clk = st_q.tclk;

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> irq); // R7
    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (tmr_clk != $past(tmr_clk))); // R8
    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_evt |=> (tmr_clk == $past(tmr_clk))); // R8
endmodule

// File: rtl/fine_reload_timer.sv
module fine_reload_timer #(
    parameter int CNT_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              preset,
    input  logic              run_set,
    input  logic              run_clr,
    input  logic              mode_oneshot,
    input  logic [FINE_W-1:0] fine_sel,
    input  logic              irq_clr,
    output logic [CNT_W-1:0]  count,
    output logic              running,
    output logic              uf_pulse,
    output logic              irq,
    output logic              tmr_clk
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             uf;
    } core_t;

    core_t     st_d, st_q;
    logic      tick_ok, zero_tick, stretch, uf_evt;
    tmr_mode_e mode;

    assign mode = tmr_mode_e'(mode_oneshot);

    always_comb begin
        tick_ok   = st_q.run && cnt_en && !preset;
        zero_tick = tick_ok && (st_q.cnt == '0);
        uf_evt    = zero_tick && !stretch;

        st_d    = st_q;
        st_d.uf = uf_evt;

        if (preset)                        st_d.cnt = reload_val;
        else if (tick_ok && st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        else if (uf_evt)                   st_d.cnt = reload_val;

        if (run_clr)                               st_d.run = 1'b0;
        else if (uf_evt && mode == MODE_ONESHOT)   st_d.run = 1'b0;
        else if (run_set)                          st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_fine_ctl #(.FINE_W(FINE_W)) u_fine (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset    (preset),
        .zero_tick (zero_tick),
        .fine_k    (fine_sel),
        .stretch   (stretch)
    );

    tmr_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .uf_evt  (uf_evt),
        .irq_clr (irq_clr),
        .irq     (irq),
        .tmr_clk (tmr_clk)
    );

    assign count    = st_q.cnt;
    assign running  = st_q.run;
    assign uf_pulse = st_q.uf;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !preset) |=> (count == $past(count))); // R2
    AST_UF_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (count == $past(reload_val))); // R3
    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (count == $past(reload_val) && !uf_pulse)); // R4
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> !running); // R5
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && mode_oneshot) |=> !running); // R6
endmodule

// File: tb/tb_fine_reload_timer.sv
module tb_fine_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       r_en = 0, r_preset = 0, r_set = 0, r_clr = 0, r_mode = 0, r_iclr = 0;
    logic [7:0] r_reload = 0;
    logic [3:0] r_fine = 0;
    logic [7:0] count;
    logic       running, uf_pulse, irq, tmr_clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_cnt = 0;
    logic [3:0] m_seq = 0;
    logic       m_hold = 0, m_run = 0, m_uf = 0, m_irq = 0, m_clk = 0;

    always #2.5 clk = ~clk;

    fine_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(r_en), .reload_val(r_reload),
        .preset(r_preset), .run_set(r_set), .run_clr(r_clr),
        .mode_oneshot(r_mode), .fine_sel(r_fine), .irq_clr(r_iclr),
        .count(count), .running(running), .uf_pulse(uf_pulse),
        .irq(irq), .tmr_clk(tmr_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model of one clock edge, written from R2..R10
    task automatic model_step();
        logic tick, uf;
        tick = m_run && r_en && !r_preset;
        uf = 1'b0;
        if (r_preset) begin
            m_cnt = r_reload; m_seq = 0; m_hold = 0;
        end else if (tick) begin
            if (m_cnt != 0) m_cnt = m_cnt - 1;
            else if (m_seq < r_fine && !m_hold) m_hold = 1;
            else begin
                m_cnt = r_reload; m_hold = 0; m_seq = m_seq + 1; uf = 1'b1;
            end
        end
        if (r_clr) m_run = 0;
        else if (uf && r_mode) m_run = 0;
        else if (r_set) m_run = 1;
        if (uf) m_irq = 1; else if (r_iclr) m_irq = 0;
        if (uf) m_clk = ~m_clk;
        m_uf = uf;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 count", count, m_cnt);
        chk("R3 uf_pulse", uf_pulse, m_uf);
        chk("R5 running", running, m_run);
        chk("R7 irq", irq, m_irq);
        chk("R8 tmr_clk", tmr_clk, m_clk);
        r_preset = 0; r_set = 0; r_clr = 0; r_iclr = 0;
    endtask

    task automatic steps_to_uf(output int n);
        n = 0;
        do begin step(); n++; end while (!uf_pulse && n < 600);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 running", running, 0);
        chk("R1 uf_pulse", uf_pulse, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tmr_clk", tmr_clk, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 idle ignores enable
        r_reload = 8'd7; r_preset = 1; step();
        r_en = 1; repeat (4) step();
        chk("R2 idle count", count, 7);

        // R9 fine 0: period n+1
        r_reload = 8'd4; r_fine = 0; r_preset = 1; r_set = 1; step();
        steps_to_uf(n); chk("R9 k0 period", n, 5);
        // R9 fine 1: first period of frame stretched
        r_fine = 1; r_preset = 1; step();
        steps_to_uf(n); chk("R9 k1 period", n, 6);
        steps_to_uf(n); chk("R9 index1 unstretched", n, 5);

        // R10 frame length
        r_reload = 8'd2; r_fine = 4'd5; r_preset = 1; step();
        steps_to_uf(n);
        begin
            int tot = 0;
            for (int i = 0; i < 16; i++) begin steps_to_uf(n); tot += n; end
            chk("R10 frame", tot, 16*3 + 5);
        end

        // R7 underflow vs irq_clr in same cycle
        r_fine = 0; r_preset = 1; step();
        while (count != 0) step();
        r_iclr = 1; step();
        chk("R7 set wins uf", uf_pulse, 1);
        chk("R7 set wins irq", irq, 1);
        r_iclr = 1; step();
        chk("R7 cleared", irq, 0);

        // R4 preset vs zero-count underflow
        while (count != 0) step();
        r_reload = 8'd9; r_preset = 1; step();
        chk("R4 preset count", count, 9);
        chk("R4 no pulse", uf_pulse, 0);

        // R5 set and clear together
        r_set = 1; r_clr = 1; step();
        chk("R5 clr wins", running, 0);

        // R6 one-shot
        r_mode = 1; r_reload = 8'd3; r_preset = 1; r_set = 1; step();
        steps_to_uf(n);
        chk("R6 stops at uf", running, 0);
        repeat (4) step();
        chk("R6 count held", count, 3);
        r_mode = 0;

        // random phase
        for (int i = 0; i < 6000; i++) begin
            r_en = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 199) == 0) r_reload = 8'($urandom_range(0, 12));
            if ($urandom_range(0, 149) == 0) r_fine = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 299) == 0) r_mode = ~r_mode;
            r_preset = ($urandom_range(0, 99) == 0);
            r_set = ($urandom_range(0, 19) == 0);
            r_clr = ($urandom_range(0, 119) == 0);
            r_iclr = ($urandom_range(0, 7) == 0);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule